// File: doc/BRIEF.md
# Configurable SPI Master Engine

This block is the serial side of a bridge: it accepts bytes from an upstream controller, drives them out on MOSI under a generated SCLK, and captures one byte from MISO for every byte sent. A single 8-bit setup byte picks the clock polarity, the edge on which data is sampled, the bit order and one of four fixed SCLK divide ratios. The setup byte can be written at any time. A write made during a transfer is held until the engine is idle.

A transfer is a stream of bytes offered with a valid/ready handshake. The byte marked last closes the transfer. The target device index is taken with the first byte. Its active-low select line stays low from the first byte until half an SCLK period after the final edge. The line goes low half a period before the first edge. Each received byte comes back with a one-cycle strobe. Between bytes of the same transfer, SCLK rests at its idle level with the select still asserted.

Top module: `spi_cfg_master`

## Requirements
- R1: Setup byte bits 7, 6 and 4 are reserved and have no effect on SCLK, MOSI, MISO sampling, select or timing.
- R2: Setup byte bits 3:2 pick the mode. With 00, SCLK idles low and data is sampled on the leading edge. With 01, it idles low and is sampled on the trailing edge. With 10, it idles high and is sampled on the trailing edge. With 11, it idles high and is sampled on the leading edge. Data changes on the edge that does not sample.
- R3: Setup byte bit 5 picks the order: 0 sends and receives the most significant bit first, 1 sends and receives the least significant bit first.
- R4: Setup byte bits 1:0 set the SCLK period. Codes 00, 01, 10 and 11 give 4, 16, 64 and 128 system clocks respectively, with each half period equal to half of that count.
- R5: ss_n[k] is the only select driven low for a transfer whose first byte carried tx_sel = k. It stays low and unchanged for every byte of that transfer. All selects are high at reset.
- R6: The select goes low exactly half an SCLK period before the first SCLK edge. It goes high exactly half a period after the last edge of the byte flagged last.
- R7: A setup write while busy does not alter the transfer in progress. It takes effect once the engine returns to idle.
- R8: Every byte shifted produces one rx_valid pulse, after that byte's final edge, carrying the byte captured from MISO.
- R9: SCLK sits at the idle level of the active mode whenever no transfer is in progress, including after reset (low).
- R10: tx_ready is high only when idle with no setup pending, or between bytes of an open transfer. It is never high while a byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the setup byte |
| cfg_byte | input | 8 | Setup byte (order, mode, rate) |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine takes the offered byte this cycle |
| tx_data | input | 8 | Byte to send |
| tx_last | input | 1 | Offered byte closes the transfer |
| tx_sel | input | 2 | Target select index, sampled with the first byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | A transfer is open |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low device selects |

## Verification
The bench sweeps every combination of mode, order and rate. It sets the reserved bits to a different pattern on each pass, and a device model samples and drives only on the edges that the bench derives from the setup byte. If the mode decode were swapped, the model would latch MOSI before it settles and the bytes would not match. If the reversed order were missed, the bytes would come back mirrored. If a divider were wrong, the measured half period would be off. If a reserved bit were decoded, some sweep points would change behaviour. A setup write made mid-transfer catches an engine that applies the new setup at once: its period and bytes would change partway through. Lead and lag are measured at the select edges, and the ready signal is watched mid-byte, to catch a select that moves with SCLK or a byte that is taken while bits are still shifting.

// File: rtl/spi_cfg_pkg.sv
// Shared types and setup-byte decoding for the configurable SPI master.
// Assumes a byte-wide data path; edge counts derive from the byte width.
package spi_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int EDGE_W = BIT_W + 1;

    // Active serial mode after decoding the setup byte.
    typedef struct packed {
        logic       lsb_first;
        logic       cpol;
        logic       late;      // sample on trailing edge
        logic [1:0] rate;
    } spi_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } xfer_state_t;

    // Decode the setup byte; reserved bits are not looked at.
    function automatic spi_mode_t decode_cfg(input logic [7:0] b);
        spi_mode_t m;
        m.lsb_first = b[5];
        m.cpol      = b[3];
        m.late      = b[3] ^ b[2];
        m.rate      = b[1:0];
        return m;
    endfunction

endpackage

// File: rtl/spi_cfg_latch.sv
// Holds the setup requested by the host and the setup in use.
// A write is stored as pending; it is copied into the active setup only
// while the engine reports idle, so a transfer never sees a change.
module spi_cfg_latch
    import spi_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_byte,
    input  logic       idle,
    output spi_mode_t  mode_act,
    output logic       cfg_dirty
);

    spi_mode_t pend_q;

    // Capture writes and promote them to active when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            mode_act  <= '0;
            cfg_dirty <= 1'b0;
        end else if (cfg_wr) begin
            pend_q    <= decode_cfg(cfg_byte);
            cfg_dirty <= 1'b1;
        end else if (idle && cfg_dirty) begin
            mode_act  <= pend_q;
            cfg_dirty <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_half_timer.sv
// Half-period timer for SCLK. Counts down from reload to zero and flags
// tick on the zero cycle, then reloads. A restart reloads at once so the
// first tick comes exactly reload+1 cycles later.
module spi_half_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    // Down-counter with self-reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/spi_xfer_fsm.sv
// Byte sequencer of the SPI master: handshake, select, SCLK edges,
// MOSI changes and MISO sampling. Assumes the mode is stable while busy
// and that tick pulses once per half period after timer_restart.
module spi_xfer_fsm
    import spi_cfg_pkg::*;
#(
    parameter int NUM_SS = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_mode_t         mode,
    input  logic              cfg_dirty,
    input  logic              tick,
    output logic              timer_restart,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic [SEL_W-1:0]  tx_sel,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);

    xfer_state_t       state_q;
    logic [EDGE_W-1:0] edge_q;
    logic [BYTE_W-1:0] tbyte_q;
    logic [BYTE_W-1:0] rbuf_q;
    logic              last_q;
    logic              accept;
    logic              samp_edge;
    logic              chg_ok;
    logic [BIT_W-1:0]  bit_idx;
    logic [BIT_W:0]    chg_idx;
    logic [NUM_SS-1:0] sel_hot;

    // Map a bit count to its position in the byte for the active order.
    function automatic logic [BIT_W-1:0] wpos(input logic [BIT_W-1:0] i,
                                              input logic lsb);
        return lsb ? i : (BIT_W'(BYTE_W - 1) - i);
    endfunction

    // One decoder line per select output.
    generate
        for (genvar g = 0; g < NUM_SS; g++) begin : g_sel
            assign sel_hot[g] = (tx_sel == SEL_W'(g));
        end
    endgenerate

    assign tx_ready      = ((state_q == ST_IDLE) && !cfg_dirty) || (state_q == ST_GAP);
    assign accept        = tx_valid && tx_ready;
    assign timer_restart = accept;
    assign busy          = (state_q != ST_IDLE);

    // Classify the coming edge: sample or change, and which bit.
    always_comb begin
        bit_idx   = edge_q[EDGE_W-1:1];
        samp_edge = (edge_q[0] == mode.late);
        chg_idx   = mode.late ? {1'b0, bit_idx} : ({1'b0, bit_idx} + 1'b1);
        chg_ok    = !chg_idx[BIT_W];
    end

    // Sequencer registers and serial outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            edge_q   <= '0;
            tbyte_q  <= '0;
            rbuf_q   <= '0;
            last_q   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            sclk     <= 1'b0;
            mosi     <= 1'b0;
            ss_n     <= '1;
        end else begin
            rx_valid <= 1'b0;
            case (state_q)
                ST_IDLE, ST_GAP: begin
                    if (state_q == ST_IDLE) begin
                        sclk <= mode.cpol;
                    end
                    if (accept) begin
                        tbyte_q <= tx_data;
                        last_q  <= tx_last;
                        edge_q  <= '0;
                        mosi    <= tx_data[wpos('0, mode.lsb_first)];
                        state_q <= ST_SHIFT;
                        if (state_q == ST_IDLE) begin
                            ss_n <= ~sel_hot;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk <= ~sclk;
                        if (samp_edge) begin
                            rbuf_q[wpos(bit_idx, mode.lsb_first)] <= miso;
                        end else if (chg_ok) begin
                            mosi <= tbyte_q[wpos(chg_idx[BIT_W-1:0], mode.lsb_first)];
                        end
                        edge_q <= edge_q + 1'b1;
                        if (&edge_q) begin
                            state_q <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        rx_valid <= 1'b1;
                        rx_data  <= rbuf_q;
                        if (last_q) begin
                            ss_n    <= '1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_GAP;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_cfg_master.sv
// Top of the configurable SPI master: setup latch, half-period timer and
// byte sequencer. The SCLK period is one of four parameterised divide
// ratios of clk; DIV3 is assumed to be the largest and all are even.
module spi_cfg_master
    import spi_cfg_pkg::*;
#(
    parameter  int NUM_SS = 4,
    parameter  int DIV0   = 4,
    parameter  int DIV1   = 16,
    parameter  int DIV2   = 64,
    parameter  int DIV3   = 128,
    localparam int SEL_W  = $clog2(NUM_SS),
    localparam int CNT_W  = $clog2(DIV3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_byte,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic [SEL_W-1:0]  tx_sel,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n
);

    spi_mode_t        mode_act;
    logic             cfg_dirty;
    logic             tick;
    logic             timer_restart;
    logic [CNT_W-1:0] half_m1;

    // Pick the half-period reload for the active rate code.
    always_comb begin
        case (mode_act.rate)
            2'd0:    half_m1 = CNT_W'(DIV0 / 2 - 1);
            2'd1:    half_m1 = CNT_W'(DIV1 / 2 - 1);
            2'd2:    half_m1 = CNT_W'(DIV2 / 2 - 1);
            default: half_m1 = CNT_W'(DIV3 / 2 - 1);
        endcase
    end

    spi_cfg_latch u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_byte  (cfg_byte),
        .idle      (!busy),
        .mode_act  (mode_act),
        .cfg_dirty (cfg_dirty)
    );

    spi_half_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .reload  (half_m1),
        .tick    (tick)
    );

    spi_xfer_fsm #(.NUM_SS(NUM_SS), .SEL_W(SEL_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode_act),
        .cfg_dirty     (cfg_dirty),
        .tick          (tick),
        .timer_restart (timer_restart),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .tx_data       (tx_data),
        .tx_last       (tx_last),
        .tx_sel        (tx_sel),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .busy          (busy),
        .sclk          (sclk),
        .mosi          (mosi),
        .miso          (miso),
        .ss_n          (ss_n)
    );

endmodule

// File: rtl/spi_cfg_master_chk.sv
// Property checker for spi_cfg_master, attached by bind. Observes ports
// and the active setup; drives nothing.
module spi_cfg_master_chk
    import spi_cfg_pkg::*;
#(
    parameter int NUM_SS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sclk,
    input logic [NUM_SS-1:0] ss_n,
    input logic              rx_valid,
    input logic              tx_ready,
    input spi_mode_t         act_mode
);

    // R5: never more than one select low
    p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ss_n));

    // R5: select pattern fixed for the whole transfer
    p_select_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ss_n));

    // R6: all selects high whenever no transfer is open
    p_idle_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&ss_n));

    // R7: active setup frozen while a transfer runs
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(act_mode));

    // R8: received bytes appear only at the end of transfer activity
    p_rx_in_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(busy));

    // R9: SCLK rests at the active idle level when not transferring
    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(act_mode.cpol)) |-> (sclk == act_mode.cpol));

    // R10: ready inside a transfer only with SCLK parked and select held
    p_ready_parked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && busy) |-> ((sclk == act_mode.cpol) && !(&ss_n)));

endmodule

bind spi_cfg_master spi_cfg_master_chk #(.NUM_SS(NUM_SS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sclk     (sclk),
    .ss_n     (ss_n),
    .rx_valid (rx_valid),
    .tx_ready (tx_ready),
    .act_mode (mode_act)
);

// File: tb/spi_cfg_master_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every mode/order/rate with a device model
// that samples and drives on edges derived from the setup byte.
module spi_cfg_master_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_byte = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] tx_data = '0;
    logic       tx_last = 1'b0;
    logic [1:0] tx_sel = '0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       busy;
    logic       sclk;
    logic       mosi;
    logic       miso = 1'b0;
    logic [3:0] ss_n;

    spi_cfg_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_sel(tx_sel), .rx_valid(rx_valid),
        .rx_data(rx_data), .busy(busy), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ss_n(ss_n)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // expected mode, from the setup byte by the stated rules
    logic e_cpol = 0, e_late = 0, e_lsb = 0;
    int   e_half = 2;
    logic [3:0] e_ssn = 4'hF;

    logic [7:0] tx_q [0:7];
    logic [7:0] sl_q [0:7];
    logic [7:0] sl_got [0:7];
    logic [7:0] dut_got [0:7];
    logic [7:0] sl_acc = 0;
    int sl_k = 0, sl_bi = 0, n_dut = 0, ie = 0, cyc = 0;
    int lead = -1, lag = -1, t_fall = 0, t_edge = 0;
    int gap_err = 0, ss_err = 0, rdy_err = 0;
    bit first_seen = 0, ended = 0, leading;
    logic sclk_at_end = 0;
    logic prev_sclk = 0;
    logic [3:0] prev_ssn = 4'hF;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic slave_bit(input int bi, input int k);
        logic [7:0] b;
        b = sl_q[bi & 7];
        return e_lsb ? b[k] : b[7-k];
    endfunction

    task automatic expect_cfg(input logic [7:0] b);
        e_cpol = b[3];
        e_late = b[3] ^ b[2];
        e_lsb  = b[5];
        e_half = (b[1:0] == 2'd3) ? 64 : (2 << (2 * b[1:0]));
    endtask

    task automatic write_cfg(input logic [7:0] b);
        @(negedge clk);
        cfg_byte = b;
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    // device model and port monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_ssn == 4'hF && ss_n != 4'hF) begin
                t_fall = cyc; first_seen = 0; sl_k = 0; sl_bi = 0; ie = 0; sl_acc = 0;
                if (!e_late) miso = slave_bit(0, 0);
            end
            if (ss_n != 4'hF && ss_n != e_ssn) ss_err++;
            if (ss_n != 4'hF && sclk != prev_sclk) begin
                if (!first_seen) begin
                    lead = cyc - t_fall;
                    first_seen = 1;
                end else if (ie != 0 && (cyc - t_edge) != e_half) begin
                    gap_err++;
                end
                t_edge = cyc;
                leading = (sclk != e_cpol);
                if (leading == !e_late) begin
                    if (e_lsb) sl_acc[sl_k] = mosi; else sl_acc[7-sl_k] = mosi;
                    sl_k++;
                    if (sl_k == 8) begin
                        sl_got[sl_bi & 7] = sl_acc;
                        sl_bi++;
                        sl_k = 0;
                        sl_acc = 0;
                    end
                end else begin
                    miso = slave_bit(sl_bi, sl_k);
                end
                ie = (ie == 15) ? 0 : ie + 1;
            end
            if (prev_ssn != 4'hF && ss_n == 4'hF) begin
                lag = cyc - t_edge;
                sclk_at_end = sclk;
                ended = 1;
            end
            if (tx_ready && ss_n != 4'hF && ie != 0) rdy_err++;
            if (rx_valid) begin
                if (n_dut < 8) dut_got[n_dut] = rx_data;
                n_dut++;
            end
        end
        prev_sclk = sclk;
        prev_ssn  = ss_n;
    end

    task automatic run_xfer(input int n, input int sel, input int t);
        string rq;
        for (int j = 0; j < 8; j++) begin
            tx_q[j]   = 8'((t * 37 + j * 101 + 5) & 255);
            sl_q[j]   = 8'((t * 53 + j * 29 + 166) & 255);
            sl_got[j] = 8'h00;
        end
        @(posedge clk);
        n_dut = 0; gap_err = 0; ss_err = 0; rdy_err = 0;
        ended = 0; lead = -1; lag = -1;
        e_ssn = ~(4'b0001 << sel);
        @(negedge clk);
        chk("R9", "sclk idle before start", int'(sclk), int'(e_cpol));
        for (int j = 0; j < n; j++) begin
            tx_valid = 1'b1;
            tx_data  = tx_q[j];
            tx_last  = (j == n - 1);
            tx_sel   = 2'(sel);
            while (!tx_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            tx_valid = 1'b0;
        end
        while (!ended) @(negedge clk);
        repeat (4) @(negedge clk);
        rq = e_lsb ? "R3" : "R2";
        for (int j = 0; j < n; j++) begin
            chk(rq, "byte seen on MOSI", int'(sl_got[j]), int'(tx_q[j]));
        end
        chk("R8", "rx strobes", n_dut, n);
        for (int j = 0; j < n && j < 8; j++) begin
            chk("R8", "byte from MISO", int'(dut_got[j]), int'(sl_q[j]));
        end
        chk("R4", "half periods off", gap_err, 0);
        chk("R6", "select lead", lead, e_half);
        chk("R6", "select lag", lag, e_half);
        chk("R5", "wrong select cycles", ss_err, 0);
        chk("R10", "ready mid-byte", rdy_err, 0);
        chk("R9", "sclk idle at end", int'(sclk_at_end), int'(e_cpol));
    endtask

    initial begin
        logic [7:0] cb;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset sclk", int'(sclk), 0);
        chk("R5", "reset selects", int'(ss_n), 15);
        chk("R10", "reset ready", int'(tx_ready), 1);
        chk("R8", "reset rx strobe", int'(rx_valid), 0);

        // sweep: rate c[1:0], mode c[3:2], order c[4]; reserved bits vary
        for (int c = 0; c < 32; c++) begin
            cb = {c[1:0] ^ 2'b01, c[4], c[2], c[3:2], c[1:0]};
            write_cfg(cb);
            expect_cfg(cb);
            repeat (3) @(negedge clk);
            run_xfer(1 + (c % 3), (c >> 1) % 4, c);
        end

        // R1: all reserved bits set, mode 00, msb first, fastest rate
        write_cfg(8'hD0);
        expect_cfg(8'hD0);
        repeat (3) @(negedge clk);
        chk("R1", "idle level with reserved bits", int'(sclk), 0);
        run_xfer(2, 3, 77);
        chk("R1", "msb-first despite reserved bits", int'(sl_got[0]), int'(tx_q[0]));

        // R7: setup written mid-transfer must wait for idle
        write_cfg(8'h04);
        expect_cfg(8'h04);
        repeat (3) @(negedge clk);
        fork
            run_xfer(3, 2, 40);
            begin
                repeat (12) @(negedge clk);
                cfg_byte = 8'h29;
                cfg_wr   = 1'b1;
                @(negedge clk);
                cfg_wr   = 1'b0;
            end
        join
        chk("R7", "old setup kept to the end", gap_err, 0);
        expect_cfg(8'h29);
        repeat (3) @(negedge clk);
        chk("R7", "new idle level after transfer", int'(sclk), 1);
        run_xfer(2, 1, 41);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule